// File: doc/BRIEF.md
# Watchdog Overflow Reset Control Register

This block is the reset control and status register that sits next to an 8-bit watchdog up-counter. When the counter wraps in watchdog mode, the block latches a sticky overflow flag. A software-owned enable bit then picks one of two outcomes. With the enable set, the block raises a one-cycle internal system reset. With it clear, the block raises a one-cycle pulse that clears only the timer's own counter and control register. In interval timer mode a wrap leaves the register alone and produces neither pulse.

Software reads the register as a plain byte. It writes through a 16-bit port, and a write counts only when its upper byte carries a key. The flag cannot be set by software. Software can clear it only by first reading it as 1 and then writing a zero to it. The external reset and the deep-standby reset initialise the register. The internal reset that the block itself produces does not, so after a watchdog reset the flag and the enable are still visible to boot code.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: Asserting `ext_rst` or `dstby_rst` at a clock edge loads the register so that `rd_data` reads 8'h1F. It also clears the read-armed state and both pulse outputs.
- R2: `rd_data[5:0]` always reads 6'b011111, whatever value the write port carries.
- R3: An `ovf_pulse` with `wd_mode`=1 sets the flag, which is `rd_data[7]`, at that clock edge.
- R4: An `ovf_pulse` with `wd_mode`=0 sets no flag and produces neither pulse output.
- R5: An accepted write whose low byte has bit 7 at 0 clears the flag only if a read strobe returned the flag as 1 in an earlier cycle, and no accepted write has happened since that read. Any accepted write cancels that armed state. Writing 1 to bit 7 never sets the flag.
- R6: With the enable bit (`rd_data[6]`) at 1, a watchdog-mode overflow drives `sys_rst_pulse` high for exactly the one cycle after the overflow edge, and `tmr_clr_pulse` stays low.
- R7: With the enable bit at 0, a watchdog-mode overflow drives `tmr_clr_pulse` high for exactly one cycle in the same way, and `sys_rst_pulse` stays low. The two pulses are never high together.
- R8: A write is accepted only when `wr_word[15:8]` equals 8'h5A. On an accepted write, `wr_word[6]` becomes the enable bit. Any other upper byte leaves the register unchanged.
- R9: If a watchdog-mode overflow and a valid clearing write arrive in the same cycle, the flag ends up set.
- R10: The register keeps its flag and enable values through and after its own `sys_rst_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst | input | 1 | External reset pin, synchronous, active high |
| dstby_rst | input | 1 | Deep-standby reset, synchronous, active high |
| rd_stb | input | 1 | Bus read strobe for the register |
| rd_data | output | 8 | Register read value |
| wr_stb | input | 1 | Write strobe for the 16-bit write port |
| wr_word | input | 16 | Write word: key in [15:8], data in [7:0] |
| ovf_pulse | input | 1 | Counter wrapped from FFh to 00h, one cycle |
| wd_mode | input | 1 | 1 = watchdog mode, 0 = interval timer mode |
| sys_rst_pulse | output | 1 | Internal system reset request, one cycle |
| tmr_clr_pulse | output | 1 | Timer-only clear request, one cycle |

## Verification
The bench sweeps all 256 key bytes and all 256 data bytes, computing the expected read value arithmetically. A design that decodes the key loosely would change the enable on a bad key. A design that exposes write data in the fixed bits would read back something other than 6'b011111 in the low bits. Directed sequences then go after the clearing rule. They cover a zero-write with no prior read, a read taken while the flag was 0, and a write that cancels the armed state. A design that lets software clear the flag without a read would lose an overflow record that software never saw. The bench also checks an overflow in interval mode, an overflow racing a clearing write, and the state after the self-generated reset. A design that wired its own reset pulse into the register would come out of that reset reading 8'h1F instead of 8'hDF.

// File: rtl/wdrc_pkg.sv
package wdrc_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned FLAG_POS = REG_W - 1;
  localparam int unsigned EN_POS   = REG_W - 2;
  localparam int unsigned FIX_W    = REG_W - 2;
  localparam logic [FIX_W-1:0] FIX_VAL = 6'b011111;
  localparam logic [REG_W-1:0] WR_KEY  = 8'h5A;

  typedef enum logic [1:0] {
    OUT_NONE = 2'b00,
    OUT_SYS  = 2'b01,
    OUT_TMR  = 2'b10
  } pulse_sel_t;
endpackage

// File: rtl/wdrc_wr_gate.sv
module wdrc_wr_gate #(
  parameter int unsigned DATA_W = wdrc_pkg::REG_W,
  parameter logic [DATA_W-1:0] KEY = wdrc_pkg::WR_KEY,
  localparam int unsigned WORD_W = 2 * DATA_W
) (
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  output logic              wr_ok,
  output logic              wr_flag_bit,
  output logic              wr_en_bit
);
  logic [DATA_W-1:0] key_byte;
  logic [DATA_W-1:0] data_byte;
  logic              unused_low;

  assign key_byte    = wr_word[WORD_W-1:DATA_W];
  assign data_byte   = wr_word[DATA_W-1:0];
  assign wr_ok       = wr_stb && (key_byte == KEY);
  assign wr_flag_bit = data_byte[DATA_W-1];
  assign wr_en_bit   = data_byte[DATA_W-2];
  assign unused_low  = ^data_byte[DATA_W-3:0];
endmodule

// File: rtl/wdrc_flag.sv
module wdrc_flag (
  input  logic clk,
  input  logic por,
  input  logic set_ev,
  input  logic rd_stb,
  input  logic wr_ok,
  input  logic wr_flag_bit,
  output logic flag_q,
  output logic arm_q
);
  logic clr_req;

  assign clr_req = wr_ok && !wr_flag_bit && arm_q;

  always_ff @(posedge clk) begin
    if (por) begin
      flag_q <= 1'b0;
    end else if (set_ev) begin
      flag_q <= 1'b1;
    end else if (clr_req) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      arm_q <= 1'b0;
    end else if (wr_ok) begin
      arm_q <= 1'b0;
    end else if (rd_stb && flag_q) begin
      arm_q <= 1'b1;
    end
  end

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (por)
    set_ev |=> flag_q); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (por)
    (set_ev && wr_ok && !wr_flag_bit && arm_q) |=> flag_q); // R9
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (por)
    (flag_q && !arm_q) |=> flag_q); // R5
  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (por)
    wr_ok |=> !arm_q); // R5
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (por)
    (!flag_q && !set_ev) |=> !flag_q); // R5
endmodule

// File: rtl/wdrc_en_reg.sv
module wdrc_en_reg (
  input  logic clk,
  input  logic por,
  input  logic wr_ok,
  input  logic wr_en_bit,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (por) begin
      en_q <= 1'b0;
    end else if (wr_ok) begin
      en_q <= wr_en_bit;
    end
  end

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (por)
    !wr_ok |=> $stable(en_q)); // R8
endmodule

// File: rtl/wdrc_pulse_gen.sv
module wdrc_pulse_gen (
  input  logic clk,
  input  logic por,
  input  logic set_ev,
  input  logic en_q,
  output logic sys_rst_pulse,
  output logic tmr_clr_pulse
);
  import wdrc_pkg::*;

  pulse_sel_t sel_d;
  pulse_sel_t sel_q;

  always_comb begin
    sel_d = OUT_NONE;
    if (set_ev) begin
      sel_d = en_q ? OUT_SYS : OUT_TMR;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      sel_q <= OUT_NONE;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sys_rst_pulse = (sel_q == OUT_SYS);
  assign tmr_clr_pulse = (sel_q == OUT_TMR);

  AST_SYS_PULSE: assert property (@(posedge clk) disable iff (por)
    (set_ev && en_q) |=> (sys_rst_pulse && !tmr_clr_pulse)); // R6
  AST_TMR_PULSE: assert property (@(posedge clk) disable iff (por)
    (set_ev && !en_q) |=> (tmr_clr_pulse && !sys_rst_pulse)); // R7
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (por)
    !set_ev |=> (!sys_rst_pulse && !tmr_clr_pulse)); // R6
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (por)
    $onehot0({sys_rst_pulse, tmr_clr_pulse})); // R7
endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl #(
  parameter int unsigned DATA_W = wdrc_pkg::REG_W,
  parameter logic [DATA_W-1:0] KEY = wdrc_pkg::WR_KEY,
  parameter logic [DATA_W-3:0] FIX_VAL = wdrc_pkg::FIX_VAL,
  localparam int unsigned WORD_W = 2 * DATA_W,
  localparam int unsigned FIX_W = DATA_W - 2
) (
  input  logic              clk,
  input  logic              ext_rst,
  input  logic              dstby_rst,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              ovf_pulse,
  input  logic              wd_mode,
  output logic              sys_rst_pulse,
  output logic              tmr_clr_pulse
);
  logic por;
  logic set_ev;
  logic wr_ok;
  logic wr_flag_bit;
  logic wr_en_bit;
  logic flag_q;
  logic arm_q;
  logic en_q;

  // Only the pin and deep-standby resets reach the register.
  assign por    = ext_rst || dstby_rst;
  assign set_ev = ovf_pulse && wd_mode;

  wdrc_wr_gate #(.DATA_W(DATA_W), .KEY(KEY)) u_wr_gate (
    .wr_stb      (wr_stb),
    .wr_word     (wr_word),
    .wr_ok       (wr_ok),
    .wr_flag_bit (wr_flag_bit),
    .wr_en_bit   (wr_en_bit)
  );

  wdrc_flag u_flag (
    .clk         (clk),
    .por         (por),
    .set_ev      (set_ev),
    .rd_stb      (rd_stb),
    .wr_ok       (wr_ok),
    .wr_flag_bit (wr_flag_bit),
    .flag_q      (flag_q),
    .arm_q       (arm_q)
  );

  wdrc_en_reg u_en (
    .clk       (clk),
    .por       (por),
    .wr_ok     (wr_ok),
    .wr_en_bit (wr_en_bit),
    .en_q      (en_q)
  );

  wdrc_pulse_gen u_pulse (
    .clk           (clk),
    .por           (por),
    .set_ev        (set_ev),
    .en_q          (en_q),
    .sys_rst_pulse (sys_rst_pulse),
    .tmr_clr_pulse (tmr_clr_pulse)
  );

  assign rd_data[DATA_W-1] = flag_q;
  assign rd_data[DATA_W-2] = en_q;
  for (genvar b = 0; b < FIX_W; b++) begin : g_fix
    assign rd_data[b] = FIX_VAL[b];
  end

  AST_INTERVAL_NO_FLAG: assert property (@(posedge clk) disable iff (por)
    (!wd_mode && !rd_data[DATA_W-1]) |=> !rd_data[DATA_W-1]); // R4
  AST_INTERVAL_NO_PULSE: assert property (@(posedge clk) disable iff (por)
    !wd_mode |=> (!sys_rst_pulse && !tmr_clr_pulse)); // R4
  AST_BAD_KEY_HOLDS_EN: assert property (@(posedge clk) disable iff (por)
    (wr_word[WORD_W-1:DATA_W] != KEY) |=> $stable(rd_data[DATA_W-2])); // R8
  AST_SELF_RST_KEEPS: assert property (@(posedge clk) disable iff (por)
    sys_rst_pulse |-> rd_data[DATA_W-1]); // R10
endmodule

// File: tb/test_wdt_rst_ctrl.sv
module test_wdt_rst_ctrl;
  localparam int CLK_P = 10;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        ext_rst = 1'b1;
  logic        dstby_rst = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_data;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_word = '0;
  logic        ovf_pulse = 1'b0;
  logic        wd_mode = 1'b1;
  logic        sys_rst_pulse;
  logic        tmr_clr_pulse;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt_rst_ctrl i_wdt_rst_ctrl (
    .clk           (clk),
    .ext_rst       (ext_rst),
    .dstby_rst     (dstby_rst),
    .rd_stb        (rd_stb),
    .rd_data       (rd_data),
    .wr_stb        (wr_stb),
    .wr_word       (wr_word),
    .ovf_pulse     (ovf_pulse),
    .wd_mode       (wd_mode),
    .sys_rst_pulse (sys_rst_pulse),
    .tmr_clr_pulse (tmr_clr_pulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One cycle: inputs already set after a falling edge, result seen at the next falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; ovf_pulse = 1'b0;
    ext_rst = 1'b0; dstby_rst = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] w);
    wr_stb = 1'b1; wr_word = w; tick();
  endtask

  task automatic do_read();
    rd_stb = 1'b1; tick();
  endtask

  task automatic do_ovf(input logic mode);
    wd_mode = mode; ovf_pulse = 1'b1; tick();
  endtask

  function automatic logic [7:0] pulses();
    return {6'b0, tmr_clr_pulse, sys_rst_pulse};
  endfunction

  initial begin
    #(CLK_P * WD_LIMIT);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    ext_rst = 1'b1; tick();
    chk("R1 ext reset value", rd_data, 8'h1F);
    chk("R1 pulses idle", pulses(), 8'h00);

    // R2 / R8: every data byte with the good key; flag is 0 and cannot be set by software.
    for (int lo = 0; lo < 256; lo++) begin
      do_write({8'h5A, 8'(lo)});
      chk("R2 fixed bits and R8 enable load", rd_data, {1'b0, lo[6], 6'b011111});
    end

    // R8: every bad key tries to set the enable.
    do_write(16'h5A00);
    for (int k = 0; k < 256; k++) begin
      if (k != 8'h5A) begin
        do_write({8'(k), 8'h40});
        chk("R8 bad key rejected", rd_data, 8'h1F);
      end
    end
    do_write(16'h5A40);
    chk("R8 good key accepted", rd_data, 8'h5F);
    do_write(16'h5A00);

    // R4: overflow in interval mode.
    do_ovf(1'b0);
    chk("R4 interval no flag", rd_data, 8'h1F);
    chk("R4 interval no pulse", pulses(), 8'h00);

    // R5: a read while the flag is 0 does not arm.
    do_read();
    do_ovf(1'b1);
    chk("R3 flag set", rd_data, 8'h9F);
    chk("R7 timer clear pulse", pulses(), 8'h02);
    tick();
    chk("R7 pulse one cycle", pulses(), 8'h00);
    do_write(16'h5A00);
    chk("R5 stale read does not arm", rd_data, 8'h9F);

    // R5: zero-write without a read.
    do_write(16'h5A00);
    chk("R5 clear without read ignored", rd_data, 8'h9F);

    // R5: read, then an accepted write with bit 7 = 1 disarms.
    do_read();
    do_write(16'h5A80);
    chk("R5 write of 1 keeps flag", rd_data, 8'h9F);
    do_write(16'h5A00);
    chk("R5 disarmed by prior write", rd_data, 8'h9F);

    // R5: read, then a bad-key write (not accepted), then a good clear.
    do_read();
    do_write(16'hA500);
    do_write(16'h5A00);
    chk("R5 read then clear", rd_data, 8'h1F);

    // R9: armed clear racing a new overflow.
    do_ovf(1'b1);
    do_read();
    wr_stb = 1'b1; wr_word = 16'h5A00; ovf_pulse = 1'b1; wd_mode = 1'b1; tick();
    chk("R9 set wins", rd_data, 8'h9F);
    tick();

    // R6 / R10: clear the flag and enable the reset, then overflow.
    do_read();
    do_write(16'h5A40);
    chk("R5 clear with enable write", rd_data, 8'h5F);
    do_ovf(1'b1);
    chk("R6 system reset pulse", pulses(), 8'h01);
    chk("R10 value during pulse", rd_data, 8'hDF);
    tick();
    chk("R6 pulse one cycle", pulses(), 8'h00);
    chk("R10 value after pulse", rd_data, 8'hDF);
    tick(); tick();
    chk("R10 value held", rd_data, 8'hDF);

    // R1: deep-standby reset and arm clearing.
    do_read();
    dstby_rst = 1'b1; tick();
    chk("R1 standby reset value", rd_data, 8'h1F);
    do_ovf(1'b1);
    do_write(16'h5A00);
    chk("R1 reset clears arm", rd_data, 8'h9F);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule